// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the software-facing half of an SPI master. A 32-bit register window, addressed by byte offset, holds the configuration words that a separate serial shift engine consumes. The window also gives a single data port that feeds an 8-entry transmit queue and drains an 8-entry receive queue. A read-only status word, an interrupt-enable word and a combined interrupt status/clear word let software poll the block or take interrupts.

Toward the engine the block offers a valid/ready pull interface on the transmit queue and a push strobe into the receive queue. It also takes completion pulses and a busy level from the engine. The clock-select, transmit-format, receive-format and frame words are stored whole and driven out unchanged. Their meaning belongs to the engine. Bus accesses are single-cycle requests: a write takes effect at the clock edge where it is requested, and read data is registered at that same edge.

Top module: `spi_fe_top`

## Requirements
- R1: After reset all stored words, flags, thresholds and both queues are zero or empty. `irq` and `bus_rdata` are 0, and the status word (offset 0x14) reads 0x20.
- R2: Offsets 0x04, 0x08, 0x0C and 0x10 read back all 32 written bits and drive them on the matching `cfg_*` outputs. Offset 0x00 keeps only bit 0, which is the enable. Offset 0x18 keeps only bit 3 (receive-complete enable) and bit 0 (overrun enable).
- R3: A write to offset 0x24 appends the low DATA_W bits to the transmit queue. The engine sees the words in write order on `eng_tx_data`, and each is removed when `eng_tx_valid` and `eng_tx_ready` are both high. `eng_tx_valid` stays low while enable bit 0 is clear.
- R4: A data-port write while the transmit queue holds 8 words is dropped. Status bit 5 (transmit not full) is 0 exactly while the queue is full.
- R5: A read of offset 0x24 returns and removes the oldest receive word. On an empty queue it returns 0 and removes nothing. Status bit 0 is 1 while the receive queue is not empty.
- R6: An `eng_rx_push` that arrives when the receive queue is full, with no pop in the same cycle, discards its word and sets overrun, bit 0 of offset 0x1C. The flag stays set until software clears it.
- R7: Writing offset 0x1C clears overrun (bit 0), receive-complete (bit 3) and transmit-complete (bit 4) wherever the written bit is 1. Zero bits leave their flags alone. A set event in the same cycle as a clear wins.
- R8: An `eng_rx_done` pulse sets bit 3 of offset 0x1C. An `eng_tx_done` pulse sets bit 4.
- R9: Bit 9 of offset 0x1C is 1 when the receive queue is non-empty and its fill level is at least the receive threshold, which is bits 3:0 of offset 0x20.
- R10: In a write to offset 0x20, bit 12 empties the transmit queue and bit 4 empties the receive queue, both at that edge. Bits 11:8 and 3:0 store the transmit and receive thresholds. The flush bits always read back as 0.
- R11: Status bit 7 (busy) is 1 when `eng_busy` is high or the transmit queue is not empty.
- R12: `irq` is a register that goes high one cycle after an enabled flag is set, where the flag is receive-complete with IE bit 3 or overrun with IE bit 0. It falls one cycle after no enabled flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered at the request edge |
| eng_tx_valid | output | 1 | Transmit word available and block enabled |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_tx_ready | input | 1 | Engine takes the transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_busy | input | 1 | Engine is shifting |
| eng_tx_done | input | 1 | Transmit-complete pulse |
| eng_rx_done | input | 1 | Receive-complete pulse |
| cfg_enable | output | 1 | Global enable |
| cfg_clksel | output | 32 | Clock-select word |
| cfg_txfmt | output | 32 | Transmit format word |
| cfg_rxfmt | output | 32 | Receive format word |
| cfg_frame | output | 32 | Frame control word |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 6-bit offset, 32-bit words and 8-entry queues. A depth of 8 lets a handful of directed pushes reach the full and overrun corners. Because the 4-bit threshold field can hold values above 8, a setting of 9 shows that bit 9 never rises even when the receive queue is full. Random mixes of engine pushes and data-port reads compare every returned word, and the sticky overrun flag, against a queue model kept in the bench.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  // Register byte offsets
  localparam int unsigned OFF_CTRL   = 32'h00;
  localparam int unsigned OFF_CLKSEL = 32'h04;
  localparam int unsigned OFF_TXFMT  = 32'h08;
  localparam int unsigned OFF_RXFMT  = 32'h0C;
  localparam int unsigned OFF_FRAME  = 32'h10;
  localparam int unsigned OFF_STAT   = 32'h14;
  localparam int unsigned OFF_IEN    = 32'h18;
  localparam int unsigned OFF_IFLAG  = 32'h1C;
  localparam int unsigned OFF_QCTL   = 32'h20;
  localparam int unsigned OFF_DATA   = 32'h24;

  // Status bits
  localparam int unsigned ST_BUSY   = 7;
  localparam int unsigned ST_TXROOM = 5;
  localparam int unsigned ST_RXAVL  = 0;

  // Interrupt flag word bits
  localparam int unsigned IF_RXLVL = 9;
  localparam int unsigned IF_TXC   = 4;
  localparam int unsigned IF_RXC   = 3;
  localparam int unsigned IF_ORUN  = 0;

  // Queue control bits
  localparam int unsigned QC_TXFLUSH = 12;
  localparam int unsigned QC_TXTH_LO = 8;
  localparam int unsigned QC_RXFLUSH = 4;
  localparam int unsigned QC_RXTH_LO = 0;
  localparam int unsigned TH_W       = 4;

  // Index of each sticky flag inside the flag vector
  localparam int unsigned FLAG_ORUN = 0;
  localparam int unsigned FLAG_RXC  = 1;
  localparam int unsigned FLAG_TXC  = 2;
  localparam int unsigned NFLAG     = 3;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             pop_ok,
  output logic             push_ok
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop & ~empty & ~flush;
  assign push_ok = push & ~flush & (~full | pop_ok);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  assign dout = mem[rptr];
endmodule

// File: rtl/spi_fe_irq.sv
module spi_fe_irq #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_evt,
  input  logic [NF-1:0] clr_req,
  input  logic [NF-1:0] en_mask,
  output logic [NF-1:0] flags,
  output logic          irq
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr_req[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & en_mask);
  end
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_ready,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_busy,
  input  logic              eng_tx_done,
  input  logic              eng_rx_done,
  output logic              cfg_enable,
  output logic [31:0]       cfg_clksel,
  output logic [31:0]       cfg_txfmt,
  output logic [31:0]       cfg_rxfmt,
  output logic [31:0]       cfg_frame,
  output logic              irq
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  // Address decode
  logic hit_ctrl, hit_clk, hit_txf, hit_rxf, hit_frm, hit_ien, hit_iflg, hit_qctl, hit_data;
  assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_clk  = (bus_addr == ADDR_W'(OFF_CLKSEL));
  assign hit_txf  = (bus_addr == ADDR_W'(OFF_TXFMT));
  assign hit_rxf  = (bus_addr == ADDR_W'(OFF_RXFMT));
  assign hit_frm  = (bus_addr == ADDR_W'(OFF_FRAME));
  assign hit_ien  = (bus_addr == ADDR_W'(OFF_IEN));
  assign hit_iflg = (bus_addr == ADDR_W'(OFF_IFLAG));
  assign hit_qctl = (bus_addr == ADDR_W'(OFF_QCTL));
  assign hit_data = (bus_addr == ADDR_W'(OFF_DATA));

  // Configuration storage
  logic            ctrl_en;
  logic            ie_rxc, ie_orun;
  logic [TH_W-1:0] tx_thr, rx_thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      cfg_clksel <= '0;
      cfg_txfmt  <= '0;
      cfg_rxfmt  <= '0;
      cfg_frame  <= '0;
      ie_rxc     <= 1'b0;
      ie_orun    <= 1'b0;
      tx_thr     <= '0;
      rx_thr     <= '0;
    end else if (bus_wr) begin
      if (hit_ctrl) ctrl_en    <= bus_wdata[0];
      if (hit_clk)  cfg_clksel <= bus_wdata;
      if (hit_txf)  cfg_txfmt  <= bus_wdata;
      if (hit_rxf)  cfg_rxfmt  <= bus_wdata;
      if (hit_frm)  cfg_frame  <= bus_wdata;
      if (hit_ien) begin
        ie_rxc  <= bus_wdata[IF_RXC];
        ie_orun <= bus_wdata[IF_ORUN];
      end
      if (hit_qctl) begin
        tx_thr <= bus_wdata[QC_TXTH_LO +: TH_W];
        rx_thr <= bus_wdata[QC_RXTH_LO +: TH_W];
      end
    end
  end
  assign cfg_enable = ctrl_en;

  // Queue control strobes (self-clearing, never stored)
  logic tx_flush, rx_flush;
  assign tx_flush = bus_wr & hit_qctl & bus_wdata[QC_TXFLUSH];
  assign rx_flush = bus_wr & hit_qctl & bus_wdata[QC_RXFLUSH];

  // Transmit queue
  logic [DATA_W-1:0] tx_head;
  logic [CW-1:0]     tx_count;
  logic              tx_full, tx_empty, tx_pop_ok, tx_push_ok;

  spi_fe_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk     (clk),
    .rst     (rst),
    .flush   (tx_flush),
    .push    (bus_wr & hit_data),
    .din     (bus_wdata[DATA_W-1:0]),
    .pop     (eng_tx_valid & eng_tx_ready),
    .dout    (tx_head),
    .count   (tx_count),
    .full    (tx_full),
    .empty   (tx_empty),
    .pop_ok  (tx_pop_ok),
    .push_ok (tx_push_ok)
  );
  assign eng_tx_valid = ctrl_en & ~tx_empty;
  assign eng_tx_data  = tx_head;

  // Receive queue
  logic [DATA_W-1:0] rx_head;
  logic [CW-1:0]     rx_count;
  logic              rx_full, rx_empty, rx_pop_ok, rx_push_ok;

  spi_fe_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk     (clk),
    .rst     (rst),
    .flush   (rx_flush),
    .push    (eng_rx_push),
    .din     (eng_rx_data),
    .pop     (bus_rd & hit_data),
    .dout    (rx_head),
    .count   (rx_count),
    .full    (rx_full),
    .empty   (rx_empty),
    .pop_ok  (rx_pop_ok),
    .push_ok (rx_push_ok)
  );

  // Interrupt flags
  logic [NFLAG-1:0] set_evt, clr_req, en_mask, flags;
  logic             orun_evt;
  assign orun_evt = eng_rx_push & ~rx_push_ok & ~rx_flush;

  always_comb begin
    set_evt            = '0;
    set_evt[FLAG_ORUN] = orun_evt;
    set_evt[FLAG_RXC]  = eng_rx_done;
    set_evt[FLAG_TXC]  = eng_tx_done;
    clr_req            = '0;
    clr_req[FLAG_ORUN] = bus_wr & hit_iflg & bus_wdata[IF_ORUN];
    clr_req[FLAG_RXC]  = bus_wr & hit_iflg & bus_wdata[IF_RXC];
    clr_req[FLAG_TXC]  = bus_wr & hit_iflg & bus_wdata[IF_TXC];
    en_mask            = '0;
    en_mask[FLAG_ORUN] = ie_orun;
    en_mask[FLAG_RXC]  = ie_rxc;
  end

  spi_fe_irq #(.NF(NFLAG)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_evt (set_evt),
    .clr_req (clr_req),
    .en_mask (en_mask),
    .flags   (flags),
    .irq     (irq)
  );

  // Receive level indication
  logic rx_lvl;
  assign rx_lvl = ~rx_empty & (32'(rx_count) >= 32'(rx_thr));

  // Read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux[0] = ctrl_en;
    if (hit_clk)  rd_mux = cfg_clksel;
    if (hit_txf)  rd_mux = cfg_txfmt;
    if (hit_rxf)  rd_mux = cfg_rxfmt;
    if (hit_frm)  rd_mux = cfg_frame;
    if (hit_ien) begin
      rd_mux[IF_RXC]  = ie_rxc;
      rd_mux[IF_ORUN] = ie_orun;
    end
    if (hit_qctl) begin
      rd_mux[QC_TXTH_LO +: TH_W] = tx_thr;
      rd_mux[QC_RXTH_LO +: TH_W] = rx_thr;
    end
    if (bus_addr == ADDR_W'(OFF_STAT)) begin
      rd_mux[ST_BUSY]   = eng_busy | ~tx_empty;
      rd_mux[ST_TXROOM] = ~tx_full;
      rd_mux[ST_RXAVL]  = ~rx_empty;
    end
    if (hit_iflg) begin
      rd_mux[IF_RXLVL] = rx_lvl;
      rd_mux[IF_TXC]   = flags[FLAG_TXC];
      rd_mux[IF_RXC]   = flags[FLAG_RXC];
      rd_mux[IF_ORUN]  = flags[FLAG_ORUN];
    end
    if (hit_data && !rx_empty) rd_mux[DATA_W-1:0] = rx_head;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk
  import spi_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic              tx_full,
  input logic              tx_pop_ok,
  input logic              rx_full,
  input logic              rx_empty,
  input logic              rx_pop_ok,
  input logic              rx_flush,
  input logic              eng_rx_push,
  input logic [2:0]        flags
);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (32'(tx_count) <= DEPTH) && (32'(rx_count) <= DEPTH));

  assert_full_write_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_DATA) && tx_full && !tx_pop_ok)
      |=> $stable(tx_count));

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_DATA) && rx_empty) |=> (bus_rdata == 32'd0));

  assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rx_full && !rx_pop_ok && !rx_flush) |=> flags[FLAG_ORUN]);

  assert_tx_flush_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_QCTL) && bus_wdata[QC_TXFLUSH]) |=> (tx_count == '0));
endmodule

bind spi_fe_top spi_fe_chk #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .tx_count    (tx_count),
  .rx_count    (rx_count),
  .tx_full     (tx_full),
  .tx_pop_ok   (tx_pop_ok),
  .rx_full     (rx_full),
  .rx_empty    (rx_empty),
  .rx_pop_ok   (rx_pop_ok),
  .rx_flush    (rx_flush),
  .eng_rx_push (eng_rx_push),
  .flags       (flags)
);

// File: tb/spi_fe_top_tb.sv
module spi_fe_top_tb;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          eng_tx_valid;
  logic [DW-1:0] eng_tx_data;
  logic          eng_tx_ready = 1'b0;
  logic          eng_rx_push = 1'b0;
  logic [DW-1:0] eng_rx_data = '0;
  logic          eng_busy = 1'b0, eng_tx_done = 1'b0, eng_rx_done = 1'b0;
  logic          cfg_enable;
  logic [31:0]   cfg_clksel, cfg_txfmt, cfg_rxfmt, cfg_frame;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_fe_top #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(8)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid),
    .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .eng_tx_done(eng_tx_done),
    .eng_rx_done(eng_rx_done), .cfg_enable(cfg_enable), .cfg_clksel(cfg_clksel),
    .cfg_txfmt(cfg_txfmt), .cfg_rxfmt(cfg_rxfmt), .cfg_frame(cfg_frame), .irq(irq)
  );

  localparam logic [AW-1:0] A_CTRL = 6'h00, A_CLK = 6'h04, A_TXF = 6'h08, A_RXF = 6'h0C,
                            A_FRM = 6'h10, A_STAT = 6'h14, A_IEN = 6'h18, A_IFLG = 6'h1C,
                            A_QCTL = 6'h20, A_DATA = 6'h24;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic take(output logic v, output logic [DW-1:0] d);
    @(negedge clk); v = eng_tx_valid; d = eng_tx_data; eng_tx_ready = 1'b1;
    @(negedge clk); eng_tx_ready = 1'b0;
  endtask

  function automatic logic [31:0] bitof(input logic [31:0] w, input int b);
    return {31'b0, w[b]};
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] base, input int i);
    return base ^ (32'h01010101 * i);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, w;
    logic        tv;
    logic [31:0] q[$];
    bit          ovr;
    int          dummy;
    dummy = $urandom(32'd20240517);

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    chk("R1 tx_valid", {31'b0, eng_tx_valid}, 32'd0);
    rd(A_STAT, v); chk("R1 status", v, 32'h20);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_IFLG, v); chk("R1 iflag", v, 32'h0);
    rd(A_QCTL, v); chk("R1 qctl", v, 32'h0);

    // R2 readback
    wr(A_CLK, 32'hA5A51234); rd(A_CLK, v); chk("R2 clksel", v, 32'hA5A51234);
    chk("R2 cfg_clksel", cfg_clksel, 32'hA5A51234);
    w = $urandom; wr(A_TXF, w); rd(A_TXF, v); chk("R2 txfmt", v, w);
    chk("R2 cfg_txfmt", cfg_txfmt, w);
    w = $urandom; wr(A_RXF, w); rd(A_RXF, v); chk("R2 rxfmt", v, w);
    w = $urandom; wr(A_FRM, w); rd(A_FRM, v); chk("R2 frame", v, w);
    chk("R2 cfg_frame", cfg_frame, w);
    wr(A_CTRL, 32'hFFFFFFFF); rd(A_CTRL, v); chk("R2 ctrl", v, 32'h1);
    wr(A_IEN, 32'hFFFFFFFF); rd(A_IEN, v); chk("R2 ien", v, 32'h9);
    wr(A_IEN, 32'h0);
    wr(A_CTRL, 32'h0);

    // R3 transmit order and enable gating
    for (int i = 0; i < 3; i++) wr(A_DATA, word_at(32'h11223344, i));
    chk("R3 gated", {31'b0, eng_tx_valid}, 32'd0);
    rd(A_STAT, v); chk("R11 busy tx", bitof(v, 7), 32'd1);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 3; i++) begin
      take(tv, w);
      chk("R3 valid", {31'b0, tv}, 32'd1);
      chk("R3 order", w, word_at(32'h11223344, i));
    end
    rd(A_STAT, v); chk("R11 idle", bitof(v, 7), 32'd0);
    eng_busy = 1'b1;
    rd(A_STAT, v); chk("R11 engine busy", bitof(v, 7), 32'd1);
    eng_busy = 1'b0;

    // R4 full transmit queue drops the ninth write
    wr(A_CTRL, 32'h0);
    for (int i = 0; i < 9; i++) wr(A_DATA, word_at(32'hCAFE0000, i));
    rd(A_STAT, v); chk("R4 txroom full", bitof(v, 5), 32'd0);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 8; i++) begin
      take(tv, w);
      chk("R4 drain", w, word_at(32'hCAFE0000, i));
    end
    @(negedge clk); chk("R4 ninth dropped", {31'b0, eng_tx_valid}, 32'd0);
    rd(A_STAT, v); chk("R4 txroom", bitof(v, 5), 32'd1);

    // R10 flushes and thresholds
    wr(A_CTRL, 32'h0);
    wr(A_DATA, 32'h1); wr(A_DATA, 32'h2);
    wr(A_QCTL, 32'h1503); rd(A_QCTL, v); chk("R10 qctl readback", v, 32'h0503);
    rd(A_STAT, v); chk("R10 tx flushed", bitof(v, 7), 32'd0);
    push(32'h77); push(32'h78); push(32'h79);
    rd(A_STAT, v); chk("R5 rx avail", bitof(v, 0), 32'd1);
    wr(A_QCTL, 32'h0013); rd(A_STAT, v); chk("R10 rx flushed", bitof(v, 0), 32'd0);
    rd(A_DATA, v); chk("R10 rx empty after flush", v, 32'd0);

    // R9 receive level
    push(32'hA0); push(32'hA1);
    rd(A_IFLG, v); chk("R9 below", bitof(v, 9), 32'd0);
    push(32'hA2);
    rd(A_IFLG, v); chk("R9 at threshold", bitof(v, 9), 32'd1);
    wr(A_QCTL, 32'h0009);
    for (int i = 0; i < 5; i++) push(32'hB0 + i);
    rd(A_IFLG, v); chk("R9 threshold above depth", bitof(v, 9), 32'd0);
    wr(A_QCTL, 32'h0000);
    rd(A_IFLG, v); chk("R9 zero threshold", bitof(v, 9), 32'd1);
    wr(A_QCTL, 32'h0010);
    rd(A_IFLG, v); chk("R9 empty", bitof(v, 9), 32'd0);

    // R6 overrun
    wr(A_IEN, 32'h1);
    for (int i = 0; i < 8; i++) push(word_at(32'h5A000000, i));
    rd(A_IFLG, v); chk("R6 no overrun yet", bitof(v, 0), 32'd0);
    chk("R12 irq quiet", {31'b0, irq}, 32'd0);
    push(32'hDEADBEEF);
    rd(A_IFLG, v); chk("R6 overrun set", bitof(v, 0), 32'd1);
    chk("R12 irq on overrun", {31'b0, irq}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      rd(A_DATA, v); chk("R6 kept words", v, word_at(32'h5A000000, i));
    end
    rd(A_DATA, v); chk("R6 dropped word", v, 32'd0);
    rd(A_IFLG, v); chk("R6 sticky", bitof(v, 0), 32'd1);
    wr(A_IFLG, 32'h0); rd(A_IFLG, v); chk("R7 zero write keeps", bitof(v, 0), 32'd1);
    wr(A_IFLG, 32'h1); rd(A_IFLG, v); chk("R7 clear overrun", bitof(v, 0), 32'd0);
    chk("R12 irq released", {31'b0, irq}, 32'd0);

    // R8 completion flags, R12 masking
    @(negedge clk); eng_rx_done = 1'b1; @(negedge clk); eng_rx_done = 1'b0;
    @(negedge clk); eng_tx_done = 1'b1; @(negedge clk); eng_tx_done = 1'b0;
    rd(A_IFLG, v);
    chk("R8 rx complete", bitof(v, 3), 32'd1);
    chk("R8 tx complete", bitof(v, 4), 32'd1);
    chk("R12 masked", {31'b0, irq}, 32'd0);
    wr(A_IEN, 32'h8); @(negedge clk);
    chk("R12 rx complete irq", {31'b0, irq}, 32'd1);
    wr(A_IFLG, 32'h18); rd(A_IFLG, v); chk("R7 clear both", v & 32'h18, 32'h0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_IFLG; bus_wdata = 32'h8; eng_rx_done = 1'b1;
    @(negedge clk); bus_wr = 1'b0; eng_rx_done = 1'b0;
    rd(A_IFLG, v); chk("R7 set wins", bitof(v, 3), 32'd1);
    wr(A_IFLG, 32'h19); wr(A_IEN, 32'h0);

    // R5 empty read
    rd(A_DATA, v); chk("R5 empty read", v, 32'd0);
    rd(A_STAT, v); chk("R5 empty status", bitof(v, 0), 32'd0);

    // Random receive traffic against a queue model (R5, R6)
    ovr = 0;
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 1) == 0) begin
        w = $urandom;
        push(w);
        if (q.size() < 8) q.push_back(w); else ovr = 1;
      end else begin
        w = (q.size() != 0) ? q.pop_front() : 32'd0;
        rd(A_DATA, v); chk("R5 random read", v, w);
      end
      if (n % 25 == 24) begin
        rd(A_IFLG, v); chk("R6 random overrun", bitof(v, 0), {31'b0, ovr});
        rd(A_STAT, v); chk("R5 random avail", bitof(v, 0), {31'b0, q.size() != 0});
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule